// File: doc/BRIEF.md
# Capture-Compare General Purpose Timer

A 16-bit up-counting timer driven by a selectable count clock, with an 8-bit prescaler in front of it. The count clock is either stopped, the system clock, the system clock divided by a fixed ratio, or falling edges on an external timer input. When the counter arrives at a programmed reference value, a reference event is flagged. The counter then either wraps to zero or keeps running, and an output pin either gives a one-cycle low pulse or toggles.

The same timer input can also capture the counter. On a selected edge of the synchronised input, the counter value is copied into a read-only capture register and a capture event is flagged. Event flags are set whether or not their interrupt enables are on. The interrupt request combines each flag with its enable. Software clears a flag by writing a 1 to it.

Software reaches the block through a single-cycle register port: a write strobe, an address and write data, plus a combinational read-data output.

Top module: `gp_timer`

## Requirements
- R1: The clock-source field of the mode register selects the count source: 00 stops the counter, 01 counts every system clock, 10 counts once per 16 system clocks spent with this source selected, and 11 counts falling edges of the synchronised timer input.
- R2: The prescaler field is 8 bits wide. It divides the selected source by the field value plus one, so 0 gives one count per source pulse and 255 gives one count per 256 source pulses.
- R3: The counter is a 16-bit up-counter. Reading it through the register port has no effect on its value or on counting.
- R4: The timer input passes through a two-flop synchroniser, and its edges are detected on the synchronised level. In source 11, each falling edge is one source pulse.
- R5: Writing the counter address loads the written value and clears the prescaler phase and the divide-by-16 phase.
- R6: A count step is a reference match when the incremented value equals the reference register. With the restart bit set, the counter loads 0 on that step instead of the reference value.
- R7: With the restart bit clear, the counter keeps incrementing past the reference. Every match still raises a reference event.
- R8: The event register holds the reference event in bit 0 and the capture event in bit 1. Each bit is set on its event regardless of the interrupt enables.
- R9: In output mode 0, the output pin goes low for exactly one system clock after each reference match and is high otherwise. The pin is high after reset.
- R10: In output mode 1, the output pin inverts once for every reference match.
- R11: The interrupt request is high exactly when event bit 0 is set with the reference-interrupt enable on, or event bit 1 is set with a non-zero capture field.
- R12: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. An event arriving in the same cycle as the clear keeps the bit set.
- R13: The capture field selects the capture edge: 00 none, 01 rising, 10 falling, 11 both. A selected edge copies the counter into the capture register. Writes to the capture address have no effect.
- R14: Register addresses are 0 mode, 1 reference, 2 capture, 3 counter and 4 events. Mode bits are [1:0] clock source, [2] restart, [3] reference-interrupt enable, [4] output mode, [6:5] capture field and [15:8] prescaler. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data, combinational from address |
| tin_i | input | 1 | Asynchronous timer input (count clock and capture) |
| tout_o | output | 1 | Timer output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the timer with its defaults: a 16-bit counter, an 8-bit prescaler, a divide-by-16 slow source and a two-stage synchroniser. With a 16-cycle divider, a 64-cycle window shows an exact count of four slow pulses, so the slow source and its interaction with the prescaler can be checked in a short run. Small reference values keep restart periods to a few cycles, which lets the bench count output pulses and toggles one by one. With the count stopped, each capture-edge setting can be checked against fixed counter values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SRC_STOP = 2'b00,
      SRC_MAIN = 2'b01,
      SRC_SLOW = 2'b10,
      SRC_PIN  = 2'b11
   } clk_src_e;

   typedef enum logic [1:0] {
      CAP_OFF  = 2'b00,
      CAP_RISE = 2'b01,
      CAP_FALL = 2'b10,
      CAP_BOTH = 2'b11
   } cap_edge_e;

   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
   localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
   localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
   localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;

   localparam int EV_REF = 0;
   localparam int EV_CAP = 1;
   localparam int EV_W   = 2;

   localparam int M_SRC_LO  = 0;
   localparam int M_RESTART = 2;
   localparam int M_REF_IE  = 3;
   localparam int M_TOGGLE  = 4;
   localparam int M_CAP_LO  = 5;
   localparam int M_PS_LO   = 8;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shift_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         shift_q <= {shift_q[STAGES-2:0], pin_i};
         prev_q  <= shift_q[STAGES-1];
      end
   end

   assign rise_o = shift_q[STAGES-1] & ~prev_q;
   assign fall_o = ~shift_q[STAGES-1] & prev_q;

   assert_edge_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_o && fall_o));
   assert_edge_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
   import tmr_pkg::*;
#(
   parameter int PRE_W    = 8,
   parameter int SLOW_DIV = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       src_i,
   input  logic [PRE_W-1:0] ps_i,
   input  logic             pin_fall_i,
   input  logic             clr_i,
   output logic             tick_o
);
   if (PRE_W < 1 || SLOW_DIV < 1) begin : g_bad_params
      $error("tmr_tick_gen: PRE_W and SLOW_DIV must be positive");
   end

   logic slow_pulse;

   if (SLOW_DIV == 1) begin : g_no_div
      assign slow_pulse = (src_i == SRC_SLOW);
   end else begin : g_div
      localparam int DW = $clog2(SLOW_DIV);
      localparam logic [DW-1:0] D_LAST = DW'(SLOW_DIV - 1);
      localparam logic [DW-1:0] D_ONE  = DW'(1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  div_q <= '0;
         else if (clr_i)              div_q <= '0;
         else if (src_i == SRC_SLOW)  div_q <= (div_q == D_LAST) ? '0 : div_q + D_ONE;
      end

      assign slow_pulse = (src_i == SRC_SLOW) && (div_q == D_LAST);
   end

   logic src_pulse;
   always_comb begin
      unique case (src_i)
         SRC_STOP: src_pulse = 1'b0;
         SRC_MAIN: src_pulse = 1'b1;
         SRC_SLOW: src_pulse = slow_pulse;
         default:  src_pulse = pin_fall_i;
      endcase
   end

   localparam logic [PRE_W-1:0] P_ONE = PRE_W'(1);
   logic [PRE_W-1:0] pcnt_q;
   logic             wrap;

   assign wrap = (pcnt_q >= ps_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pcnt_q <= '0;
      else if (clr_i)      pcnt_q <= '0;
      else if (src_pulse)  pcnt_q <= wrap ? '0 : pcnt_q + P_ONE;
   end

   assign tick_o = src_pulse && wrap;

   assert_phase_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_pulse && !clr_i) |=> $stable(pcnt_q));
   assert_phase_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (pcnt_q == '0));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] ref_i,
   input  logic             restart_i,
   input  logic             cap_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cap_o,
   output logic             ref_hit_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("tmr_core: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cap_q;
   logic [CNT_W-1:0] nxt;

   assign nxt       = cnt_q + C_ONE;
   assign ref_hit_o = tick_i && !load_i && (nxt == ref_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load_i)  cnt_q <= load_val_i;
      else if (tick_i)  cnt_q <= (ref_hit_o && restart_i) ? '0 : nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (cap_i)  cap_q <= cnt_q;
   end

   assign cnt_o = cnt_q;
   assign cap_o = cap_q;

   assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_hit_o && restart_i) |=> (cnt_q == '0));
   assert_free_run_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_hit_o && !restart_i) |=> (cnt_q == ref_i));
   assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(cnt_q));
   assert_capture_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(cap_q));
endmodule

// File: rtl/gp_timer.sv
module gp_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 8,
   parameter int SLOW_DIV    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr_i,
   input  logic [tmr_pkg::ADDR_W-1:0] bus_addr_i,
   input  logic [CNT_W-1:0]       bus_wdata_i,
   output logic [CNT_W-1:0]       bus_rdata_o,
   input  logic                   tin_i,
   output logic                   tout_o,
   output logic                   irq_o
);
   if (CNT_W < M_PS_LO + PRE_W) begin : g_bad_layout
      $error("gp_timer: CNT_W too narrow for the mode register layout");
   end

   // register write decode
   logic wr_mode, wr_ref, wr_cnt, wr_evt;
   assign wr_mode = bus_wr_i && (bus_addr_i == A_MODE);
   assign wr_ref  = bus_wr_i && (bus_addr_i == A_REF);
   assign wr_cnt  = bus_wr_i && (bus_addr_i == A_CNT);
   assign wr_evt  = bus_wr_i && (bus_addr_i == A_EVT);

   // mode fields
   clk_src_e         src_q;
   cap_edge_e        cap_q;
   logic             restart_q, ref_ie_q, toggle_q;
   logic [PRE_W-1:0] ps_q;
   logic [CNT_W-1:0] ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q     <= SRC_STOP;
         cap_q     <= CAP_OFF;
         restart_q <= 1'b0;
         ref_ie_q  <= 1'b0;
         toggle_q  <= 1'b0;
         ps_q      <= '0;
      end else if (wr_mode) begin
         src_q     <= clk_src_e'(bus_wdata_i[M_SRC_LO +: 2]);
         cap_q     <= cap_edge_e'(bus_wdata_i[M_CAP_LO +: 2]);
         restart_q <= bus_wdata_i[M_RESTART];
         ref_ie_q  <= bus_wdata_i[M_REF_IE];
         toggle_q  <= bus_wdata_i[M_TOGGLE];
         ps_q      <= bus_wdata_i[M_PS_LO +: PRE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ref_q <= '0;
      else if (wr_ref)  ref_q <= bus_wdata_i;
   end

   // input synchroniser and edge detection
   logic pin_rise, pin_fall;

   tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (tin_i),
      .rise_o (pin_rise),
      .fall_o (pin_fall)
   );

   // count clock selection and prescaler
   logic tick;

   tmr_tick_gen #(.PRE_W(PRE_W), .SLOW_DIV(SLOW_DIV)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_q),
      .ps_i       (ps_q),
      .pin_fall_i (pin_fall),
      .clr_i      (wr_cnt),
      .tick_o     (tick)
   );

   // capture edge select
   logic cap_strobe;
   always_comb begin
      unique case (cap_q)
         CAP_OFF:  cap_strobe = 1'b0;
         CAP_RISE: cap_strobe = pin_rise;
         CAP_FALL: cap_strobe = pin_fall;
         default:  cap_strobe = pin_rise | pin_fall;
      endcase
   end

   // counter, compare and capture
   logic [CNT_W-1:0] cnt_val, cap_val;
   logic             ref_hit;

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .load_i     (wr_cnt),
      .load_val_i (bus_wdata_i),
      .ref_i      (ref_q),
      .restart_i  (restart_q),
      .cap_i      (cap_strobe),
      .cnt_o      (cnt_val),
      .cap_o      (cap_val),
      .ref_hit_o  (ref_hit)
   );

   // event flags: set has priority over write-one-to-clear
   logic [EV_W-1:0] ev_q, ev_set, ev_clr;
   assign ev_set = {cap_strobe, ref_hit};
   assign ev_clr = wr_evt ? bus_wdata_i[EV_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q <= '0;
      else        ev_q <= ev_set | (ev_q & ~ev_clr);
   end

   assign irq_o = (ev_q[EV_REF] & ref_ie_q) | (ev_q[EV_CAP] & (cap_q != CAP_OFF));

   // output pin waveform
   logic tout_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tout_q <= 1'b1;
      else if (toggle_q)  tout_q <= tout_q ^ ref_hit;
      else                tout_q <= ~ref_hit;
   end
   assign tout_o = tout_q;

   // read mux
   logic [CNT_W-1:0] mode_rd;
   always_comb begin
      mode_rd                    = '0;
      mode_rd[M_SRC_LO +: 2]     = src_q;
      mode_rd[M_RESTART]         = restart_q;
      mode_rd[M_REF_IE]          = ref_ie_q;
      mode_rd[M_TOGGLE]          = toggle_q;
      mode_rd[M_CAP_LO +: 2]     = cap_q;
      mode_rd[M_PS_LO +: PRE_W]  = ps_q;
   end

   always_comb begin
      unique case (bus_addr_i)
         A_MODE:  bus_rdata_o = mode_rd;
         A_REF:   bus_rdata_o = ref_q;
         A_CAP:   bus_rdata_o = cap_val;
         A_CNT:   bus_rdata_o = cnt_val;
         A_EVT:   bus_rdata_o = CNT_W'(ev_q);
         default: bus_rdata_o = '0;
      endcase
   end

   assert_stopped_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == SRC_STOP && !wr_cnt) |=> $stable(cnt_val));
   assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!toggle_q && !tout_o && !ref_hit) |=> tout_o);
   assert_irq_needs_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ev_q != '0));
   assert_event_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_q[EV_REF] && !wr_evt) |=> ev_q[EV_REF]);
   assert_capture_readonly_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == A_CAP && !cap_strobe) |=> $stable(cap_val));
endmodule

// File: tb/gp_timer_test.sv
module gp_timer_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        tin = 1'b0;
   logic        tout;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   gp_timer uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .tin_i       (tin),
      .tout_o      (tout),
      .irq_o       (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   localparam logic [2:0] AM = 3'd0, AR = 3'd1, AC = 3'd2, AN = 3'd3, AE = 3'd4;

   function automatic logic [15:0] mk_mode(input logic [1:0] src, input logic rs,
      input logic rie, input logic tog, input logic [1:0] ce, input logic [7:0] ps);
      return {ps, 1'b0, ce, tog, rie, rs, src};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_now(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // runs exactly n system clocks with the given mode, then stops the source
   task automatic run_cycles(input logic [15:0] mode, input int n);
      wr_reg(AM, mode);
      repeat (n-1) @(posedge clk);
      wr_reg(AM, {mode[15:2], 2'b00});
   endtask

   task automatic t_reset;
      logic [15:0] d;
      foreach (d[i]) d[i] = 1'b0;
      rd_now(AN, d); chk("R14 counter reset", d, 0);
      rd_now(AM, d); chk("R14 mode reset", d, 0);
      rd_now(AE, d); chk("R14 events reset", d, 0);
      rd_now(AC, d); chk("R14 capture reset", d, 0);
      chk("R9 tout high at reset", tout, 1);
      chk("R11 irq low at reset", irq, 0);
      wr_reg(AM, 16'hAB7D & 16'hFF7F);
      rd_now(AM, d); chk("R14 mode readback", d, 16'hAB7D & 16'hFF7F);
      wr_reg(AM, 16'h0000);
   endtask

   task automatic t_sources;
      logic [15:0] d;
      wr_reg(AN, 16'd0);
      run_cycles(mk_mode(2'b01, 0, 0, 0, 2'b00, 8'd0), 10);
      rd_now(AN, d); chk("R1 main clock count", d, 10);
      rd_now(AN, d); chk("R3 read does not disturb", d, 10);
      repeat (5) @(negedge clk);
      rd_now(AN, d); chk("R1 stopped source holds", d, 10);
      wr_reg(AN, 16'd0);
      run_cycles(mk_mode(2'b10, 0, 0, 0, 2'b00, 8'd0), 64);
      rd_now(AN, d); chk("R1 slow source div16", d, 4);
      wr_reg(AN, 16'd0);
      run_cycles(mk_mode(2'b10, 0, 0, 0, 2'b00, 8'd1), 64);
      rd_now(AN, d); chk("R2 slow source with prescale 2", d, 2);
   endtask

   task automatic t_prescale;
      logic [15:0] d;
      wr_reg(AN, 16'd0);
      run_cycles(mk_mode(2'b01, 0, 0, 0, 2'b00, 8'd3), 20);
      rd_now(AN, d); chk("R2 prescale 4", d, 5);
      wr_reg(AN, 16'd0);
      run_cycles(mk_mode(2'b01, 0, 0, 0, 2'b00, 8'd3), 6);
      rd_now(AN, d); chk("R2 partial phase", d, 1);
      wr_reg(AN, 16'h1234);
      rd_now(AN, d); chk("R5 counter load", d, 16'h1234);
      run_cycles(mk_mode(2'b01, 0, 0, 0, 2'b00, 8'd3), 3);
      rd_now(AN, d); chk("R5 prescale phase cleared by load", d, 16'h1234);
      wr_reg(AN, 16'd0);
      run_cycles(mk_mode(2'b01, 0, 0, 0, 2'b00, 8'd255), 256);
      rd_now(AN, d); chk("R2 prescale 256", d, 1);
   endtask

   task automatic t_pin_count;
      logic [15:0] d;
      wr_reg(AN, 16'd0);
      wr_reg(AM, mk_mode(2'b11, 0, 0, 0, 2'b00, 8'd0));
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); tin = 1'b1;
         repeat (3) @(negedge clk);
         tin = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      rd_now(AN, d); chk("R4 falling edges counted", d, 3);
      wr_reg(AM, 16'h0000);
   endtask

   task automatic t_restart_pulse;
      logic [15:0] d;
      int lows = 0;
      wr_reg(AR, 16'd5);
      wr_reg(AN, 16'd0);
      wr_reg(AE, 16'h0003);
      wr_reg(AM, mk_mode(2'b01, 1, 1, 0, 2'b00, 8'd0));
      for (int k = 0; k < 12; k++) begin
         @(posedge clk); @(negedge clk);
         if (tout == 1'b0) lows++;
      end
      rd_now(AN, d); chk("R6 restart wraps at reference", d, 2);
      chk("R9 one low cycle per match", lows, 2);
      rd_now(AE, d); chk("R8 reference event bit 0", d, 1);
      chk("R11 irq with enable", irq, 1);
      wr_reg(AM, 16'h0000);
      chk("R9 tout high when idle", tout, 1);
   endtask

   task automatic t_free_run;
      logic [15:0] d;
      wr_reg(AE, 16'h0003);
      wr_reg(AN, 16'd0);
      run_cycles(mk_mode(2'b01, 0, 0, 0, 2'b00, 8'd0), 10);
      rd_now(AN, d); chk("R7 free run passes reference", d, 10);
      rd_now(AE, d); chk("R7 free run event", d, 1);
      chk("R8 event without enable, irq low", irq, 0);
   endtask

   task automatic t_irq_clear;
      logic [15:0] d;
      wr_reg(AM, mk_mode(2'b00, 0, 1, 0, 2'b00, 8'd0));
      chk("R11 irq follows enable", irq, 1);
      wr_reg(AE, 16'h0002);
      rd_now(AE, d); chk("R12 write 0 keeps bit", d, 1);
      wr_reg(AE, 16'h0001);
      rd_now(AE, d); chk("R12 write 1 clears bit", d, 0);
      chk("R11 irq drops after clear", irq, 0);
      wr_reg(AM, 16'h0000);
   endtask

   task automatic t_toggle;
      int changes = 0;
      logic prev;
      wr_reg(AR, 16'd3);
      wr_reg(AN, 16'd0);
      prev = tout;
      wr_reg(AM, mk_mode(2'b01, 1, 0, 1, 2'b00, 8'd0));
      for (int k = 0; k < 12; k++) begin
         @(posedge clk); @(negedge clk);
         if (tout != prev) changes++;
         prev = tout;
      end
      chk("R10 one toggle per match", changes, 4);
      wr_reg(AM, 16'h0000);
      chk("R10 toggle level after even count", tout, 1);
   endtask

   task automatic pin_set(input logic v);
      @(negedge clk); tin = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_capture;
      logic [15:0] d;
      wr_reg(AE, 16'h0003);
      wr_reg(AM, mk_mode(2'b00, 0, 0, 0, 2'b00, 8'd0));
      wr_reg(AN, 16'h0011);
      pin_set(1'b1);
      rd_now(AC, d); chk("R13 capture off", d, 0);
      rd_now(AE, d); chk("R8 no capture event when off", d, 0);
      pin_set(1'b0);
      wr_reg(AM, mk_mode(2'b00, 0, 0, 0, 2'b01, 8'd0));
      wr_reg(AN, 16'h0042);
      pin_set(1'b1);
      rd_now(AC, d); chk("R13 rising capture", d, 16'h0042);
      rd_now(AE, d); chk("R8 capture event bit 1", d, 2);
      chk("R11 capture irq", irq, 1);
      wr_reg(AE, 16'h0002);
      wr_reg(AN, 16'h0050);
      pin_set(1'b0);
      rd_now(AC, d); chk("R13 rising ignores fall", d, 16'h0042);
      rd_now(AE, d); chk("R13 no event on ignored edge", d, 0);
      wr_reg(AM, mk_mode(2'b00, 0, 0, 0, 2'b10, 8'd0));
      wr_reg(AN, 16'h0077);
      pin_set(1'b1);
      rd_now(AC, d); chk("R13 falling ignores rise", d, 16'h0042);
      pin_set(1'b0);
      rd_now(AC, d); chk("R13 falling capture", d, 16'h0077);
      wr_reg(AM, mk_mode(2'b00, 0, 0, 0, 2'b11, 8'd0));
      wr_reg(AN, 16'h0088);
      pin_set(1'b1);
      rd_now(AC, d); chk("R13 both edges rise", d, 16'h0088);
      wr_reg(AN, 16'h0099);
      pin_set(1'b0);
      rd_now(AC, d); chk("R13 both edges fall", d, 16'h0099);
      wr_reg(AC, 16'hFFFF);
      rd_now(AC, d); chk("R13 capture write ignored", d, 16'h0099);
      wr_reg(AE, 16'h0003);
      wr_reg(AM, 16'h0000);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sources();
      t_prescale();
      t_pin_count();
      t_restart_pulse();
      t_free_run();
      t_irq_clear();
      t_toggle();
      t_capture();
      finish_run();
   end
endmodule